// File: doc/BRIEF.md
# Branch Target Address Generator

This unit produces the 32-bit destination address of a branch for a processor front end. The caller presents an already-decoded mode code, the address of the instruction after the branch, a general-register value with its operand size, an immediate field, and a pointer-size flag. It then pulses `start`. Modes that need only arithmetic finish on the next cycle. The two indirect modes take a pointer from memory. They issue a read on a request/acknowledge port and return the fetched pointer as the target.

Each calculation is bracketed by `start` and a one-cycle `done` pulse. `target` and `err` are registered when `done` rises and keep their values until the next completion. While a memory read is outstanding, `mem_req` doubles as the busy indication and new starts are dropped.

Top module: `branch_target_gen`

## Requirements
- R1: Mode code 0 (register indirect) gives a target equal to all 32 bits of `reg_val`.
- R2: Mode code 1 takes `imm[7:0]` as a two's-complement displacement, sign-extends it and adds it to `pc` modulo 2^32.
- R3: Mode code 2 takes `imm[15:0]` as a two's-complement displacement, sign-extends it and adds it to `pc` modulo 2^32.
- R4: Mode code 3 zero-extends a view of `reg_val` chosen by `reg_size`, doubles it and adds it to `pc` modulo 2^32. `reg_size` 0 selects bits [7:0], 1 selects bits [15:0], and 2 or 3 selects all 32 bits.
- R5: Mode code 4 zero-extends `imm[23:0]` to form the target. Mode code 5 uses `imm[31:0]` unchanged.
- R6: Mode code 6 raises `mem_req` with `mem_addr` equal to `imm[7:0]` zero-extended. The pointer read back becomes the target.
- R7: Mode code 7 forms an index with a 1 in bit 7 above `imm[6:0]`. `mem_addr` is that index times 2 when `ptr_long` is 0, or times 4 when `ptr_long` is 1. The pointer read back becomes the target.
- R8: For both memory modes, `ptr_long` = 0 gives `mem_rdata[15:0]` zero-extended as the target, and `ptr_long` = 1 gives all of `mem_rdata`. The flag is sampled with `start`.
- R9: `mem_req` rises one cycle after an accepted start. It stays high with `mem_addr` stable until a cycle in which `mem_ack` is high. In the next cycle `mem_req` is low and `done` is high.
- R10: For mode codes 0 to 5, `done` is high for exactly the one cycle after the start cycle. `err` is 0 on every completion of a defined mode.
- R11: A `start` seen while `mem_req` is high has no effect: no extra `done`, and the target delivered is that of the outstanding fetch.
- R12: Mode codes 8 to 15 complete one cycle after start with `target` = 0 and `err` = 1.
- R13: After reset, `done`, `mem_req`, `err`, `target` and `mem_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation with the present inputs |
| mode | input | 4 | Addressing mode code (0..7 defined) |
| pc | input | 32 | Address of the instruction after the branch |
| reg_val | input | 32 | General-register value |
| reg_size | input | 2 | Register view: 0 byte, 1 word, 2/3 long |
| imm | input | 32 | Displacement, absolute address or vector number |
| ptr_long | input | 1 | Pointer size: 0 for 16-bit, 1 for 32-bit |
| mem_req | output | 1 | Memory read request, also busy |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| target | output | 32 | Computed branch target |
| err | output | 1 | Last completion used an undefined mode |

## Verification
Arithmetic and undefined modes are due exactly one cycle after the start edge. Memory modes raise the request one cycle after start, and the result comes one cycle after the edge at which the acknowledge is sampled. The bench keeps a behavioural model that steps on the same rising edge as the design and predicts `done`, `target`, `err`, `mem_req` and `mem_addr` for every cycle. It compares all of them on each falling edge, half a period after the registers settle. The acknowledge latency varies from zero to several cycles, so the hold and ignore windows are exercised at different lengths.

// File: rtl/btgen_pkg.sv
package btgen_pkg;
  localparam int AW     = 32;
  localparam int DSP_S  = 8;
  localparam int DSP_L  = 16;
  localparam int ABS_S  = 24;
  localparam int VEC_W  = 7;
  localparam int PTR_S  = 16;
  localparam int MPTR_W = 8;

  typedef enum logic [3:0] {
    MD_REG   = 4'd0,
    MD_PC8   = 4'd1,
    MD_PC16  = 4'd2,
    MD_PCIDX = 4'd3,
    MD_ABS24 = 4'd4,
    MD_ABS32 = 4'd5,
    MD_MIND  = 4'd6,
    MD_XMIND = 4'd7
  } bt_mode_e;

  function automatic logic [AW-1:0] sext_short(input logic [DSP_S-1:0] d);
    return {{(AW-DSP_S){d[DSP_S-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] sext_long(input logic [DSP_L-1:0] d);
    return {{(AW-DSP_L){d[DSP_L-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] index_view(input logic [AW-1:0] r,
                                               input logic [1:0] sz);
    logic [AW-1:0] v;
    case (sz)
      2'd0:    v = {{(AW-8){1'b0}}, r[7:0]};
      2'd1:    v = {{(AW-16){1'b0}}, r[15:0]};
      default: v = r;
    endcase
    return v << 1;
  endfunction

  function automatic logic [AW-1:0] vector_addr(input logic [VEC_W-1:0] vn,
                                                input logic lng);
    logic [AW-1:0] idx;
    idx = {{(AW-VEC_W-1){1'b0}}, 1'b1, vn};
    return lng ? (idx << 2) : (idx << 1);
  endfunction

  function automatic logic [AW-1:0] widen_ptr(input logic [AW-1:0] d,
                                              input logic lng);
    return lng ? d : {{(AW-PTR_S){1'b0}}, d[PTR_S-1:0]};
  endfunction
endpackage

// File: rtl/btgen_ea_unit.sv
module btgen_ea_unit
  import btgen_pkg::*;
(
  input  logic [3:0]    mode,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] reg_val,
  input  logic [1:0]    reg_size,
  input  logic [AW-1:0] imm,
  input  logic          ptr_long,
  output logic [AW-1:0] direct_tgt,
  output logic [AW-1:0] fetch_addr,
  output logic          needs_fetch,
  output logic          mode_bad
);
  always_comb begin
    direct_tgt  = '0;
    fetch_addr  = '0;
    needs_fetch = 1'b0;
    mode_bad    = 1'b0;
    case (mode)
      MD_REG:   direct_tgt = reg_val;
      MD_PC8:   direct_tgt = pc + sext_short(imm[DSP_S-1:0]);
      MD_PC16:  direct_tgt = pc + sext_long(imm[DSP_L-1:0]);
      MD_PCIDX: direct_tgt = pc + index_view(reg_val, reg_size);
      MD_ABS24: direct_tgt = {{(AW-ABS_S){1'b0}}, imm[ABS_S-1:0]};
      MD_ABS32: direct_tgt = imm;
      MD_MIND: begin
        needs_fetch = 1'b1;
        fetch_addr  = {{(AW-MPTR_W){1'b0}}, imm[MPTR_W-1:0]};
      end
      MD_XMIND: begin
        needs_fetch = 1'b1;
        fetch_addr  = vector_addr(imm[VEC_W-1:0], ptr_long);
      end
      default:  mode_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (mode == MD_XMIND)
      assert_vec_range_R7: assert (fetch_addr[AW-1:10] == '0 && fetch_addr[0] == 1'b0);
  end
endmodule

// File: rtl/btgen_fetch.sv
module btgen_fetch
  import btgen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] launch_addr,
  input  logic          launch_long,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          fetch_done,
  output logic [AW-1:0] fetch_data
);
  logic ptr_long_q;

  assign fetch_done = mem_req && mem_ack;
  assign fetch_data = widen_ptr(mem_rdata, ptr_long_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      ptr_long_q <= 1'b0;
    end else if (fetch_done) begin
      mem_req <= 1'b0;
    end else if (launch && !mem_req) begin
      mem_req    <= 1'b1;
      mem_addr   <= launch_addr;
      ptr_long_q <= launch_long;
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> !mem_req);
  assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !mem_req |=> mem_req);
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import btgen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [31:0]   pc,
  input  logic [31:0]   reg_val,
  input  logic [1:0]    reg_size,
  input  logic [31:0]   imm,
  input  logic          ptr_long,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic [31:0]   target,
  output logic          err
);
  logic [AW-1:0] direct_tgt, fetch_addr, fetch_data;
  logic          needs_fetch, mode_bad, fetch_done;
  logic          start_acc, direct_fin, fetch_launch;

  assign start_acc    = start && !mem_req;
  assign direct_fin   = start_acc && !needs_fetch;
  assign fetch_launch = start_acc && needs_fetch;

  btgen_ea_unit u_ea (
    .mode        (mode),
    .pc          (pc),
    .reg_val     (reg_val),
    .reg_size    (reg_size),
    .imm         (imm),
    .ptr_long    (ptr_long),
    .direct_tgt  (direct_tgt),
    .fetch_addr  (fetch_addr),
    .needs_fetch (needs_fetch),
    .mode_bad    (mode_bad)
  );

  btgen_fetch u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (fetch_launch),
    .launch_addr (fetch_addr),
    .launch_long (ptr_long),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .fetch_done  (fetch_done),
    .fetch_data  (fetch_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      target <= '0;
      err    <= 1'b0;
    end else begin
      done <= fetch_done || direct_fin;
      if (fetch_done) begin
        target <= fetch_data;
        err    <= 1'b0;
      end else if (direct_fin) begin
        target <= direct_tgt;
        err    <= mode_bad;
      end
    end
  end

  assert_direct_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !mem_req && mode < 4'd6 |=> done && !err);
  assert_bad_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start && !mem_req && mode > 4'd7 |=> done && err && target == '0);
  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !done);
  assert_ack_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> done && !err);
  assert_req_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && mem_req));
endmodule

// File: tb/branch_target_gen_test.sv
module branch_target_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [31:0] pc = '0, reg_val = '0, imm = '0, mem_rdata = '0;
  logic [1:0]  reg_size = '0;
  logic        ptr_long = 1'b0, mem_ack = 1'b0;
  logic        mem_req, done, err;
  logic [31:0] mem_addr, target;

  int compared = 0, mismatched = 0, cycles = 0, ack_lat = 0, wait_cnt = 0;
  bit finished = 0;

  logic        x_done = 0, x_err = 0, x_req = 0, m_long = 0;
  logic [31:0] x_target = 0, x_addr = 0;
  string       t_tgt = "R13", t_addr = "R13";

  always #10 clk = ~clk;

  branch_target_gen uut (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  // behavioural reference, stepped on the same edge as the design
  always @(posedge clk) begin
    longint t;
    if (!rst_n) begin
      x_done <= 0; x_err <= 0; x_req <= 0; x_target <= 0; x_addr <= 0;
    end else begin
      x_done <= 0;
      if (x_req) begin
        if (mem_ack) begin
          x_req <= 0; x_done <= 1; x_err <= 0;
          x_target <= m_long ? mem_rdata : (mem_rdata & 32'hFFFF);
        end
      end else if (start) begin
        t = 0;
        case (mode)
          0: begin t = reg_val; t_tgt = "R1"; end
          1: begin t = longint'(pc) + longint'($signed(imm[7:0])); t_tgt = "R2"; end
          2: begin t = longint'(pc) + longint'($signed(imm[15:0])); t_tgt = "R3"; end
          3: begin
               t = (reg_size == 0) ? (reg_val % 256) :
                   (reg_size == 1) ? (reg_val % 65536) : longint'(reg_val);
               t = longint'(pc) + 2 * t; t_tgt = "R4";
             end
          4: begin t = imm % (1 << 24); t_tgt = "R5"; end
          5: begin t = imm; t_tgt = "R5"; end
          6: begin x_req <= 1; x_addr <= imm % 256; m_long <= ptr_long;
               t_tgt = "R8"; t_addr = "R6"; end
          7: begin x_req <= 1; x_addr <= (128 + imm % 128) * (ptr_long ? 4 : 2);
               m_long <= ptr_long; t_tgt = "R8"; t_addr = "R7"; end
          default: t_tgt = "R12";
        endcase
        if (mode < 6 || mode > 7) begin
          x_done <= 1; x_target <= t[31:0]; x_err <= (mode > 7);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10", 32'(done), 32'(x_done));
      chk("R12", 32'(err), 32'(x_err));
      chk(t_tgt, target, x_target);
      chk("R9", 32'(mem_req), 32'(x_req));
      if (x_req) chk(t_addr, mem_addr, x_addr);
    end
  end

  // memory responder
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wait_cnt >= ack_lat) begin
        mem_ack <= 1; mem_rdata <= mem_word(mem_addr); wait_cnt <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end else begin
      mem_ack <= 0; mem_rdata <= 32'hDEAD_BEEF;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog: got %0d expected <50000 cycles", cycles);
      finish_run();
    end
  end

  task automatic settle();
    repeat (2) @(negedge clk);
    while (mem_req) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic go(input logic [3:0] m, input logic [31:0] p, input logic [31:0] r,
                    input logic [1:0] s, input logic [31:0] i, input logic pl);
    @(negedge clk);
    mode = m; pc = p; reg_val = r; reg_size = s; imm = i; ptr_long = pl; start = 1;
    @(negedge clk);
    start = 0;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", {done, mem_req, err}, 3'b000);
    chk("R13", target, 32'h0);
    chk("R13", mem_addr, 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    go(0, 32'h1000, 32'hCAFE_1234, 2, 0, 0);               // R1
    go(1, 32'h0000_4000, 0, 0, 32'hFFFF_FF80, 0);          // R2 negative
    go(1, 32'hFFFF_FFF0, 0, 0, 32'h0000_007F, 0);          // R2 wrap
    go(2, 32'h0001_0000, 0, 0, 32'h0000_8000, 0);          // R3 negative
    go(2, 32'hFFFF_8000, 0, 0, 32'h0000_7FFF, 0);          // R3
    go(3, 32'h2000, 32'hFFFF_FFA5, 0, 0, 0);               // R4 byte
    go(3, 32'h2000, 32'hFFFF_FFA5, 1, 0, 0);               // R4 word
    go(3, 32'h2000, 32'h8000_0001, 2, 0, 0);               // R4 long wrap
    go(3, 32'h10, 32'h0000_1234, 3, 0, 0);                 // R4 long alias
    go(4, 0, 0, 0, 32'hAB12_3456, 0);                      // R5 abs24
    go(5, 0, 0, 0, 32'hAB12_3456, 0);                      // R5 abs32
    for (int k = 0; k < 4; k++) begin
      ack_lat = k;
      go(6, 0, 0, 0, 32'hFFFF_FF00 | (k * 37 + 5), k[0]);  // R6 R8
      go(7, 0, 0, 0, 32'h0000_0000 | (k * 41), k[1]);      // R7 R8
    end
    go(7, 0, 0, 0, 32'h7F, 1);                             // R7 top vector
    go(8, 32'h55, 32'h66, 0, 32'h77, 0);                   // R12
    go(15, 32'h55, 32'h66, 0, 32'h77, 1);                  // R12
    go(0, 0, 32'h1, 0, 0, 0);                              // R12 err clears
    // R11: start during an outstanding fetch is ignored
    ack_lat = 3;
    @(negedge clk);
    mode = 6; imm = 32'h44; ptr_long = 1; start = 1;
    @(negedge clk);
    mode = 0; reg_val = 32'h1111_2222; start = 1;
    @(negedge clk);
    start = 0;
    settle();
    chk("R11", target, mem_word(32'h44));
    // back-to-back: new start in the done cycle
    ack_lat = 0;
    @(negedge clk);
    mode = 5; imm = 32'h0BAD_F00D; start = 1;
    @(negedge clk);
    mode = 7; imm = 32'h3; ptr_long = 0;
    @(negedge clk);
    start = 0;
    settle();
    chk("R8", target, mem_word(32'h106) & 32'hFFFF);
    finish_run();
  end
endmodule